// File: doc/BRIEF.md
# Two-Level Vectored Interrupt Controller

This block chooses one interrupt among eight sources and hands its vector address to the processor. The sources are four external pins (two base pins and two added pins), three timer overflow flags and a serial port flag. Timer and serial flags arrive as plain level inputs and are cleared by their owners. Each source has an enable bit and a priority bit. A global enable gates every request. The block raises `irq_req` with the winning vector and source index. The processor answers with a one-cycle `irq_ack` when it enters the handler, and with a one-cycle `irq_reti` when it returns.

The two added pins are configured through an 8-bit control register. Software can write it as a whole byte or change one bit at a time. For each added pin the register holds a priority bit, an enable bit, a pending flag and a trigger-type bit. All four pins pass through a two-flop synchronizer and then through one more sample flop. A pin set to edge mode latches a pending flag on a falling edge, and the acknowledge of that source clears the flag. A pin set to level mode reports pending whenever its synchronized sample is low.

The service tracker is a four-state machine. The states are `ST_IDLE` (no handler running), `ST_LOW` (a low-level handler running), `ST_HIGH` (a high-level handler running, entered from idle) and `ST_HIGH_OVER_LOW` (a high-level handler that preempted a low one). The transitions are:
- take-low: `ST_IDLE` to `ST_LOW`.
- take-high: `ST_IDLE` to `ST_HIGH`.
- preempt: `ST_LOW` to `ST_HIGH_OVER_LOW`.
- return-low: `ST_LOW` to `ST_IDLE`.
- return-high: `ST_HIGH` to `ST_IDLE`.
- unnest: `ST_HIGH_OVER_LOW` to `ST_LOW`.

Top module: `ivc_top`

## Requirements
- R1: Source index i (0 external pin 0, 1 timer 0, 2 external pin 1, 3 timer 1, 4 serial, 5 timer 2, 6 added pin A, 7 added pin B) is presented as `irq_src` = i with `irq_vec` = 8*i + 3 (03h, 0Bh, 13h, 1Bh, 23h, 2Bh, 33h, 3Bh).
- R2: Among candidates of equal priority level, the lowest source index wins.
- R3: A candidate whose priority bit is 1 beats every candidate whose priority bit is 0.
- R4: A source is a candidate only when `glob_en` and its own enable bit are both 1.
- R5: Control register layout, bit 7 down to 0: pin B priority, pin B enable, pin B pending, pin B trigger type, pin A priority, pin A enable, pin A pending, pin A trigger type. A byte write loads all fields. The pending bit is loaded only in edge mode; in level mode it reads back the pin state.
- R6: In edge mode (trigger type 1), a falling edge (sample 1 followed by sample 0 after two synchronizing flops) sets the pending flag. Acknowledging that source clears the flag. If a new edge and the clear fall in the same cycle, the flag stays set.
- R7: In level mode (trigger type 0), the pending bit is 1 exactly while the synchronized pin is low. Nothing is latched.
- R8: With no handler running, any candidate is requested. During a low-level handler, only high-level candidates are requested. During a high-level handler, nothing is requested. `irq_reti` returns to the state that was preempted, or to idle.
- R9: An `irq_ack` while `irq_req` is 0 leaves the state unchanged.
- R10: After reset, `irq_req` is 0, the control register reads 00h (with pins idle high) and no handler is running.
- R11: A single-bit write changes only the addressed bit of the control register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| glob_en | input | 1 | Global interrupt enable |
| src_en | input | 6 | Enable bits for sources 0..5 |
| src_prio | input | 6 | Priority bits for sources 0..5 (1 = high) |
| ext_pin_n | input | 2 | Base external pins, active low (sources 0, 2) |
| ext_edge | input | 2 | Trigger type for base pins (1 = falling edge) |
| periph_flag | input | 4 | Timer 0, timer 1, serial, timer 2 flags (sources 1, 3, 4, 5) |
| xpin_n | input | 2 | Added external pins A and B, active low (sources 6, 7) |
| xc_wr | input | 1 | Byte write strobe for the control register |
| xc_wdata | input | 8 | Byte write data |
| xc_bit_wr | input | 1 | Single-bit write strobe |
| xc_bit_idx | input | 3 | Bit position for single-bit write |
| xc_bit_val | input | 1 | Value for single-bit write |
| xc_rdata | output | 8 | Control register readback |
| irq_ack | input | 1 | Handler entry pulse |
| irq_reti | input | 1 | Handler return pulse |
| irq_req | output | 1 | Interrupt request |
| irq_vec | output | 8 | Vector address of the winner |
| irq_src | output | 3 | Source index of the winner |

## Verification
The tricky collision is the hardware clear from an acknowledge landing in the same cycle as a new falling edge on the same edge-mode pin. The bench first latches one edge on added pin A and drives the pin high again. It then drives the pin low and pulses `irq_ack` exactly on the clock edge where the synchronizer reports the fall. It judges the result by reading the pending bit back through the control register, which must still be 1. After `irq_reti`, the bench also checks that the request for vector 33h reappears. A separate sweep covers all 256 pending patterns under several enable and priority settings. Each winner is compared against a value the bench computes arithmetically.

// File: rtl/ivc_pkg.sv
package ivc_pkg;
    localparam int NSRC       = 8;
    localparam int IDX_W      = $clog2(NSRC);
    localparam int VEC_W      = 8;
    localparam int VEC_STRIDE = 8;
    localparam int VEC_BASE   = 3;
    localparam int NPIN       = 4;
    localparam int NXPIN      = 2;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOW,
        ST_HIGH,
        ST_HIGH_OVER_LOW
    } svc_state_t;

    function automatic logic [VEC_W-1:0] vec_of(input logic [IDX_W-1:0] i);
        return VEC_W'(int'(i) * VEC_STRIDE + VEC_BASE);
    endfunction

    // pin k (0,1 base pins; 2,3 added pins) -> source index
    function automatic int pin_src(input int k);
        case (k)
            0:       return 0;
            1:       return 2;
            2:       return 6;
            default: return 7;
        endcase
    endfunction
endpackage

// File: rtl/ivc_pin_detect.sv
module ivc_pin_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    input  logic edge_mode,
    input  logic sw_we,
    input  logic sw_val,
    input  logic hw_clr,
    output logic pending
);
    logic s1, s2, s3, flag, fall;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1 <= 1'b1;
            s2 <= 1'b1;
            s3 <= 1'b1;
        end else begin
            s1 <= pin_n;
            s2 <= s1;
            s3 <= s2;
        end
    end

    assign fall = s3 & ~s2;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag <= 1'b0;
        end else if (!edge_mode) begin
            flag <= 1'b0;
        end else begin
            if (fall)
                flag <= 1'b1;
            else if (hw_clr)
                flag <= 1'b0;
            else if (sw_we)
                flag <= sw_val;
        end
    end

    assign pending = edge_mode ? flag : ~s2;

    assert_fall_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_mode && fall) |=> flag);
endmodule

// File: rtl/ivc_pick.sv
module ivc_pick #(
    parameter  int N  = 8,
    localparam int IW = $clog2(N)
) (
    input  logic [N-1:0]  req,
    output logic          valid,
    output logic [IW-1:0] idx
);
    always_comb begin
        valid = |req;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/ivc_top.sv
module ivc_top
    import ivc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             glob_en,
    input  logic [5:0]       src_en,
    input  logic [5:0]       src_prio,
    input  logic [1:0]       ext_pin_n,
    input  logic [1:0]       ext_edge,
    input  logic [3:0]       periph_flag,
    input  logic [1:0]       xpin_n,
    input  logic             xc_wr,
    input  logic [7:0]       xc_wdata,
    input  logic             xc_bit_wr,
    input  logic [2:0]       xc_bit_idx,
    input  logic             xc_bit_val,
    output logic [7:0]       xc_rdata,
    input  logic             irq_ack,
    input  logic             irq_reti,
    output logic             irq_req,
    output logic [VEC_W-1:0] irq_vec,
    output logic [IDX_W-1:0] irq_src
);
    svc_state_t state, state_nx;

    logic [NXPIN-1:0] xp_px, xp_ex, xp_it;
    logic [NPIN-1:0]  pin_pend, pins_n, pin_edge;
    logic [NSRC-1:0]  pend, en_all, pr_all, live, hi_v, lo_v;
    logic             hi_ok, lo_ok, take, win_hi;
    logic [IDX_W-1:0] hi_idx, lo_idx;

    assign pins_n   = {xpin_n, ext_pin_n};
    assign pin_edge = {xp_it, ext_edge};

    // control register fields for added pins
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            xp_px <= '0;
            xp_ex <= '0;
            xp_it <= '0;
        end else if (xc_wr) begin
            for (int j = 0; j < NXPIN; j++) begin
                xp_it[j] <= xc_wdata[4*j];
                xp_ex[j] <= xc_wdata[4*j+2];
                xp_px[j] <= xc_wdata[4*j+3];
            end
        end else if (xc_bit_wr) begin
            for (int j = 0; j < NXPIN; j++) begin
                if (int'(xc_bit_idx) == 4*j)   xp_it[j] <= xc_bit_val;
                if (int'(xc_bit_idx) == 4*j+2) xp_ex[j] <= xc_bit_val;
                if (int'(xc_bit_idx) == 4*j+3) xp_px[j] <= xc_bit_val;
            end
        end
    end

    genvar k;
    generate
        for (k = 0; k < NPIN; k++) begin : g_pin
            logic sw_we, sw_val, hw_clr;
            if (k >= NPIN - NXPIN) begin : g_sw
                localparam int POS = 4 * (k - (NPIN - NXPIN)) + 1;
                assign sw_we  = xc_wr | (xc_bit_wr & (int'(xc_bit_idx) == POS));
                assign sw_val = xc_wr ? xc_wdata[POS] : xc_bit_val;
            end else begin : g_nosw
                assign sw_we  = 1'b0;
                assign sw_val = 1'b0;
            end
            assign hw_clr = take && (irq_src == IDX_W'(pin_src(k)));
            ivc_pin_detect u_det (
                .clk       (clk),
                .rst_n     (rst_n),
                .pin_n     (pins_n[k]),
                .edge_mode (pin_edge[k]),
                .sw_we     (sw_we),
                .sw_val    (sw_val),
                .hw_clr    (hw_clr),
                .pending   (pin_pend[k])
            );
        end
    endgenerate

    assign xc_rdata = {xp_px[1], xp_ex[1], pin_pend[3], xp_it[1],
                       xp_px[0], xp_ex[0], pin_pend[2], xp_it[0]};

    assign pend   = {pin_pend[3], pin_pend[2], periph_flag[3], periph_flag[2],
                     periph_flag[1], pin_pend[1], periph_flag[0], pin_pend[0]};
    assign en_all = {xp_ex, src_en};
    assign pr_all = {xp_px, src_prio};
    assign live   = glob_en ? (pend & en_all) : '0;
    assign hi_v   = live & pr_all;
    assign lo_v   = live & ~pr_all;

    ivc_pick #(.N(NSRC)) u_hi (.req(hi_v), .valid(hi_ok), .idx(hi_idx));
    ivc_pick #(.N(NSRC)) u_lo (.req(lo_v), .valid(lo_ok), .idx(lo_idx));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:          if (take) state_nx = win_hi ? ST_HIGH : ST_LOW;
            ST_LOW:           if (take) state_nx = ST_HIGH_OVER_LOW;
                              else if (irq_reti) state_nx = ST_IDLE;
            ST_HIGH:          if (irq_reti) state_nx = ST_IDLE;
            ST_HIGH_OVER_LOW: if (irq_reti) state_nx = ST_LOW;
        endcase
    end

    // outputs
    always_comb begin
        irq_req = 1'b0;
        win_hi  = 1'b0;
        irq_src = '0;
        unique case (state)
            ST_IDLE: begin
                if (hi_ok) begin
                    irq_req = 1'b1; win_hi = 1'b1; irq_src = hi_idx;
                end else if (lo_ok) begin
                    irq_req = 1'b1; irq_src = lo_idx;
                end
            end
            ST_LOW: begin
                if (hi_ok) begin
                    irq_req = 1'b1; win_hi = 1'b1; irq_src = hi_idx;
                end
            end
            ST_HIGH, ST_HIGH_OVER_LOW: irq_req = 1'b0;
        endcase
    end

    assign irq_vec = vec_of(irq_src);
    assign take    = irq_ack & irq_req;

    assert_req_gated_R4: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> glob_en);
    assert_vec_form_R1: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (irq_vec[2:0] == 3'b011 && irq_vec[7:6] == 2'b00));
    assert_hold_in_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HIGH || state == ST_HIGH_OVER_LOW) |-> !irq_req);
    assert_take_leaves_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && irq_ack && irq_req) |=> state != ST_IDLE);
    assert_unnest_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HIGH_OVER_LOW && irq_reti) |=> state == ST_LOW);
    assert_stray_ack_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack && !irq_req && !irq_reti) |=> $stable(state));
    assert_bitwr_keeps_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (xc_bit_wr && !xc_wr && xc_bit_idx != 3'd7) |=> $stable(xp_px[1]));
endmodule

// File: tb/ivc_top_test.sv
`timescale 1ns/1ps
module ivc_top_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       glob_en = 1'b0;
    logic [5:0] src_en = '0, src_prio = '0;
    logic [1:0] ext_pin_n = 2'b11, ext_edge = 2'b00, xpin_n = 2'b11;
    logic [3:0] periph_flag = '0;
    logic       xc_wr = 1'b0, xc_bit_wr = 1'b0, xc_bit_val = 1'b0;
    logic [7:0] xc_wdata = '0;
    logic [2:0] xc_bit_idx = '0;
    logic [7:0] xc_rdata;
    logic       irq_ack = 1'b0, irq_reti = 1'b0, irq_req;
    logic [7:0] irq_vec;
    logic [2:0] irq_src;

    int checks = 0, fails = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    ivc_top uut (
        .clk(clk), .rst_n(rst_n), .glob_en(glob_en), .src_en(src_en),
        .src_prio(src_prio), .ext_pin_n(ext_pin_n), .ext_edge(ext_edge),
        .periph_flag(periph_flag), .xpin_n(xpin_n), .xc_wr(xc_wr),
        .xc_wdata(xc_wdata), .xc_bit_wr(xc_bit_wr), .xc_bit_idx(xc_bit_idx),
        .xc_bit_val(xc_bit_val), .xc_rdata(xc_rdata), .irq_ack(irq_ack),
        .irq_reti(irq_reti), .irq_req(irq_req), .irq_vec(irq_vec), .irq_src(irq_src)
    );

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr_byte(input logic [7:0] d);
        xc_wr = 1'b1; xc_wdata = d;
        tick(1);
        xc_wr = 1'b0;
    endtask

    task automatic wr_bit(input int idx, input logic v);
        xc_bit_wr = 1'b1; xc_bit_idx = 3'(idx); xc_bit_val = v;
        tick(1);
        xc_bit_wr = 1'b0;
    endtask

    task automatic pulse_ack();
        irq_ack = 1'b1; tick(1); irq_ack = 1'b0;
    endtask

    task automatic pulse_reti();
        irq_reti = 1'b1; tick(1); irq_reti = 1'b0;
    endtask

    // level mode everywhere; enable/priority for all eight sources
    task automatic config_all(input logic [7:0] en, input logic [7:0] pr);
        src_en = en[5:0]; src_prio = pr[5:0]; ext_edge = 2'b00;
        wr_byte({pr[7], en[7], 2'b00, pr[6], en[6], 2'b00});
    endtask

    task automatic set_pend(input logic [7:0] m);
        ext_pin_n   = ~{m[2], m[0]};
        periph_flag = {m[5], m[4], m[3], m[1]};
        xpin_n      = ~m[7:6];
    endtask

    function automatic int exp_win(input logic [7:0] live, input logic [7:0] pr);
        for (int i = 0; i < 8; i++) if (live[i] && pr[i]) return i;
        for (int i = 0; i < 8; i++) if (live[i]) return i;
        return -1;
    endfunction

    initial begin
        #(200000 * 5);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] enp [2];
        logic [7:0] prp [4];
        enp[0] = 8'hFF; enp[1] = 8'h5A;
        prp[0] = 8'h00; prp[1] = 8'hFF; prp[2] = 8'h96; prp[3] = 8'h41;

        tick(3);
        // R10: reset state
        check("R10 req", irq_req, 0);
        check("R10 rdata", xc_rdata, 0);
        rst_n = 1'b1;
        tick(2);
        check("R10 req after release", irq_req, 0);

        // R5: byte writes and readback
        wr_byte(8'hCD);
        check("R5 readback CD", xc_rdata, 8'hCD);
        wr_byte(8'h13);
        check("R5 readback 13 edge pending loaded", xc_rdata, 8'h13);
        // R11: single-bit writes
        wr_bit(3, 1'b1);
        check("R11 set bit3", xc_rdata, 8'h1B);
        wr_bit(7, 1'b1);
        check("R11 set bit7", xc_rdata, 8'h9B);
        wr_bit(1, 1'b0);
        check("R11 clear bit1", xc_rdata, 8'h99);
        wr_byte(8'h00);

        // R9: stray ack with no request
        glob_en = 1'b1;
        config_all(8'h02, 8'h00);
        pulse_ack();
        set_pend(8'h02);
        tick(1);
        check("R9 req after stray ack", irq_req, 1);
        check("R9 vec", irq_vec, 8'h0B);
        set_pend(8'h00);
        tick(3);

        // R1 R2 R3 R4: sweep
        for (int e = 0; e < 2; e++) begin
            for (int p = 0; p < 4; p++) begin
                config_all(enp[e], prp[p]);
                for (int m = 0; m < 256; m++) begin
                    int w;
                    set_pend(8'(m));
                    tick(3);
                    w = exp_win(8'(m) & enp[e], prp[p]);
                    check("R4 R2 R3 req", irq_req, (w >= 0) ? 1 : 0);
                    if (w >= 0) begin
                        check("R2 R3 winner", irq_src, w);
                        check("R1 vector", irq_vec, w * 8 + 3);
                    end
                end
            end
        end
        // R4: global enable off
        config_all(8'hFF, 8'h00);
        glob_en = 1'b0;
        set_pend(8'hFF);
        tick(3);
        check("R4 global off", irq_req, 0);
        glob_en = 1'b1;
        tick(1);
        check("R4 global on", irq_src, 0);
        set_pend(8'h00);
        tick(3);

        // R6: edge mode on added pin A
        config_all(8'h00, 8'h00);
        wr_byte(8'h05);
        xpin_n[0] = 1'b0;
        tick(3);
        check("R6 edge sets pending", xc_rdata[1], 1);
        check("R1 pin A vector", irq_vec, 8'h33);
        xpin_n[0] = 1'b1;
        tick(4);
        check("R6 flag latched", xc_rdata[1], 1);
        // new edge coinciding with ack clear
        xpin_n[0] = 1'b0;
        tick(2);
        irq_ack = 1'b1;
        tick(1);
        irq_ack = 1'b0;
        check("R6 set beats clear", xc_rdata[1], 1);
        check("R8 low in service blocks low", irq_req, 0);
        pulse_reti();
        check("R8 return re-requests", irq_req, 1);
        check("R1 vector 33h", irq_vec, 8'h33);
        pulse_ack();
        check("R6 ack clears", xc_rdata[1], 0);
        pulse_reti();
        tick(3);
        check("R6 held low no re-set", xc_rdata[1], 0);
        check("R6 no request", irq_req, 0);
        xpin_n[0] = 1'b1;
        tick(3);

        // R7: level mode on pin B
        wr_byte(8'h40);
        xpin_n[1] = 1'b0;
        tick(3);
        check("R7 level pending", xc_rdata[5], 1);
        check("R1 vector 3Bh", irq_vec, 8'h3B);
        xpin_n[1] = 1'b1;
        tick(3);
        check("R7 not latched", xc_rdata[5], 0);
        check("R7 req drops", irq_req, 0);

        // R8: preemption
        config_all(8'h2A, 8'h20);
        set_pend(8'h02);
        tick(3);
        check("R1 timer0 vector", irq_vec, 8'h0B);
        pulse_ack();
        set_pend(8'h08);
        tick(3);
        check("R8 low blocked during low", irq_req, 0);
        set_pend(8'h28);
        tick(3);
        check("R8 high preempts", irq_req, 1);
        check("R8 high vector", irq_vec, 8'h2B);
        pulse_ack();
        tick(2);
        check("R8 nothing during high", irq_req, 0);
        set_pend(8'h08);
        pulse_reti();
        check("R8 back to low blocks low", irq_req, 0);
        pulse_reti();
        check("R8 idle allows low", irq_req, 1);
        check("R8 timer1 vector", irq_vec, 8'h1B);
        set_pend(8'h00);
        tick(2);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule